// File: doc/BRIEF.md
# Processor Register File with Banked Stack Pointer

This block holds the sixteen 32-bit architectural registers of a small processor core. It has two combinational read ports and one write port, each addressed by a 4-bit register number. Register number 13 is the stack pointer. It is not a single register: it is an alias that resolves to one of two physical copies, a main stack pointer and a process stack pointer. The copy it resolves to depends on the execution mode.

In handler mode the alias always reaches the main copy. In thread mode a stack-select input chooses between the two copies, and the main copy is the default. The copy that is not active cannot be reached through number 13. A separate special-access port reads and writes either copy by name, whatever the mode.

Number 15 returns a program-counter value that is supplied from outside the block, and writes to it are dropped. Numbers 0 to 12 and 14 are plain storage and have no defined reset value. An access can be marked as using the compact encoding, which may only name registers 0 to 7. The block raises a flag when such an access names a higher register.

Top module: `arch_regfile`

## Requirements
- R1: Registers 0 to 12 and 14 each hold the last value written to them through the write port. Both read ports return that value combinationally, with no added cycle.
- R2: `narrow_bad` is high in the same cycle whenever any of these accesses names a register of 8 or above:
  - read port A with `rd_a_narrow` = 1;
  - read port B with `rd_b_narrow` = 1;
  - the write port with `wr_en` = 1 and `wr_narrow` = 1.
  Accesses that are not marked narrow never raise the flag.
- R3: While `handler_mode` = 1, register 13 reads and writes the main stack pointer, whatever the value of `thread_psp_sel`.
- R4: While `handler_mode` = 0, register 13 resolves as follows:
  - to the process stack pointer when `thread_psp_sel` = 1;
  - to the main stack pointer when `thread_psp_sel` = 0.
- R5: The special-access port selects a stack pointer by name:
  - `sp_acc_sel` = 0 selects the main stack pointer and 1 selects the process stack pointer;
  - `sp_acc_rdata` reads the selected copy;
  - `sp_acc_we` writes the selected copy at the next edge, in any mode.
  A write to register 13 never changes the inactive copy.
- R6: A synchronous reset loads the main stack pointer from `sp_reset_val` with bits 1:0 cleared, and sets the process stack pointer to zero.
- R7: Every write to either stack pointer, through either port, stores the data with bits 1:0 forced to zero.
- R8: When the write port and the special-access port write the same physical stack pointer in one cycle, the special-access data is stored.
- R9: Reads of register 15 return `pc_in`, and writes to register 15 change no register.
- R10: A write on the write port becomes visible on the read ports after the next rising clock edge. In the cycle of the write, a read of the same register still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sp_reset_val | input | DATA_W | Value loaded into the main stack pointer on reset |
| pc_in | input | DATA_W | Value returned for reads of register 15 |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| thread_psp_sel | input | 1 | In thread mode, 1 selects the process stack pointer |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_narrow | input | 1 | Read port A uses the compact encoding |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_narrow | input | 1 | Read port B uses the compact encoding |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register number |
| wr_narrow | input | 1 | Write uses the compact encoding |
| wr_data | input | DATA_W | Write port data |
| sp_acc_sel | input | 1 | Special-access port copy select: 0 = main, 1 = process |
| sp_acc_we | input | 1 | Special-access port write enable |
| sp_acc_wdata | input | DATA_W | Special-access port write data |
| sp_acc_rdata | output | DATA_W | Special-access port read data |
| narrow_bad | output | 1 | A compact-encoding access names register 8 or above |

## Verification
The bench builds the block with `DATA_W` = 32 and `ALIGN_BITS` = 2, which is the full architectural width and word alignment. With these values, every written pattern can leave the two low bits set. This exposes any write path, including the reset path, that skips the alignment mask.

The bench model tracks which general registers have been written, and compares only those. It never relies on contents after reset. Long random runs toggle the mode and stack-select inputs between writes, so that writes to register 13 land on both copies. They also produce same-cycle collisions on the special-access port.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int IDX_W       = 4;
    localparam int NUM_ARCH    = 1 << IDX_W;
    localparam int SP_IDX      = 13;
    localparam int PC_IDX      = 15;
    localparam int NARROW_LAST = 7;

    typedef enum logic {
        SP_MAIN = 1'b0,
        SP_PROC = 1'b1
    } sp_bank_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic             narrow;
    } acc_ctl_t;

    function automatic sp_bank_e active_bank(input logic handler, input logic psel);
        return (handler || !psel) ? SP_MAIN : SP_PROC;
    endfunction

    function automatic logic narrow_violation(input acc_ctl_t a);
        return a.en && a.narrow && (int'(a.idx) > NARROW_LAST);
    endfunction

endpackage

// File: rtl/rf_gpr_array.sv
module rf_gpr_array
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    gpr_q [NUM_ARCH]
);

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_slot
        if (g == SP_IDX || g == PC_IDX) begin : g_hole
            assign gpr_q[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (wr_en && int'(wr_idx) == g) begin
                    cell_q <= wr_data;
                end
            end
            assign gpr_q[g] = cell_q;
        end
    end

endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank
    import rf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  reset_val,
    input  sp_bank_e           active,
    input  logic               norm_we,
    input  logic [DATA_W-1:0]  norm_wdata,
    input  sp_bank_e           acc_sel,
    input  logic               acc_we,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  msp_q,
    output logic [DATA_W-1:0]  psp_q
);

    localparam logic [DATA_W-1:0] ALIGN_MASK = ~{{(DATA_W-ALIGN_BITS){1'b0}}, {ALIGN_BITS{1'b1}}};

    logic main_acc, main_norm, proc_acc, proc_norm;

    always_comb begin
        main_acc  = acc_we  && (acc_sel == SP_MAIN);
        proc_acc  = acc_we  && (acc_sel == SP_PROC);
        main_norm = norm_we && (active  == SP_MAIN);
        proc_norm = norm_we && (active  == SP_PROC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msp_q <= reset_val & ALIGN_MASK;
            psp_q <= '0;
        end else begin
            if (main_acc) begin
                msp_q <= acc_wdata & ALIGN_MASK;
            end else if (main_norm) begin
                msp_q <= norm_wdata & ALIGN_MASK;
            end
            if (proc_acc) begin
                psp_q <= acc_wdata & ALIGN_MASK;
            end else if (proc_norm) begin
                psp_q <= norm_wdata & ALIGN_MASK;
            end
        end
    end

    // R7
    sp_align_chk: assert property (@(posedge clk) disable iff (rst)
        (msp_q[ALIGN_BITS-1:0] == '0) && (psp_q[ALIGN_BITS-1:0] == '0));

    // R8
    sp_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (norm_we && acc_we && (acc_sel == active) && (active == SP_PROC))
        |=> (psp_q == ($past(acc_wdata) & ALIGN_MASK)));

    // R5
    sp_idle_main_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_we && acc_sel == SP_MAIN) && !(norm_we && active == SP_MAIN)
        |=> $stable(msp_q));

    // R5
    sp_idle_proc_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_we && acc_sel == SP_PROC) && !(norm_we && active == SP_PROC)
        |=> $stable(psp_q));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  gpr_q [NUM_ARCH],
    input  logic [DATA_W-1:0]  sp_val,
    input  logic [DATA_W-1:0]  pc_val,
    output logic [DATA_W-1:0]  data
);

    always_comb begin
        if (int'(idx) == PC_IDX) begin
            data = pc_val;
        end else if (int'(idx) == SP_IDX) begin
            data = sp_val;
        end else begin
            data = gpr_q[idx];
        end
    end

endmodule

// File: rtl/arch_regfile.sv
module arch_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  sp_reset_val,
    input  logic [DATA_W-1:0]  pc_in,
    input  logic               handler_mode,
    input  logic               thread_psp_sel,
    input  logic [3:0]         rd_a_idx,
    input  logic               rd_a_narrow,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [3:0]         rd_b_idx,
    input  logic               rd_b_narrow,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [3:0]         wr_idx,
    input  logic               wr_narrow,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               sp_acc_sel,
    input  logic               sp_acc_we,
    input  logic [DATA_W-1:0]  sp_acc_wdata,
    output logic [DATA_W-1:0]  sp_acc_rdata,
    output logic               narrow_bad
);

    sp_bank_e          bank_now;
    sp_bank_e          acc_bank;
    logic              sp_norm_we;
    logic [DATA_W-1:0] msp_q, psp_q, sp_active;
    logic [DATA_W-1:0] gpr_q [NUM_ARCH];
    acc_ctl_t          acc_rd_a, acc_rd_b, acc_wr;

    always_comb begin
        bank_now   = active_bank(handler_mode, thread_psp_sel);
        acc_bank   = sp_acc_sel ? SP_PROC : SP_MAIN;
        sp_norm_we = wr_en && (int'(wr_idx) == SP_IDX);
        sp_active  = (bank_now == SP_PROC) ? psp_q : msp_q;
        acc_rd_a   = '{en: 1'b1,  idx: rd_a_idx, narrow: rd_a_narrow};
        acc_rd_b   = '{en: 1'b1,  idx: rd_b_idx, narrow: rd_b_narrow};
        acc_wr     = '{en: wr_en, idx: wr_idx,   narrow: wr_narrow};
        narrow_bad = narrow_violation(acc_rd_a) || narrow_violation(acc_rd_b)
                     || narrow_violation(acc_wr);
        sp_acc_rdata = (acc_bank == SP_PROC) ? psp_q : msp_q;
    end

    rf_gpr_array #(.DATA_W(DATA_W)) u_gpr (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .gpr_q   (gpr_q)
    );

    rf_sp_bank #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_sp (
        .clk        (clk),
        .rst        (rst),
        .reset_val  (sp_reset_val),
        .active     (bank_now),
        .norm_we    (sp_norm_we),
        .norm_wdata (wr_data),
        .acc_sel    (acc_bank),
        .acc_we     (sp_acc_we),
        .acc_wdata  (sp_acc_wdata),
        .msp_q      (msp_q),
        .psp_q      (psp_q)
    );

    rf_read_port #(.DATA_W(DATA_W)) u_rd_a (
        .idx    (rd_a_idx),
        .gpr_q  (gpr_q),
        .sp_val (sp_active),
        .pc_val (pc_in),
        .data   (rd_a_data)
    );

    rf_read_port #(.DATA_W(DATA_W)) u_rd_b (
        .idx    (rd_b_idx),
        .gpr_q  (gpr_q),
        .sp_val (sp_active),
        .pc_val (pc_in),
        .data   (rd_b_data)
    );

    // R3
    handler_main_chk: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && int'(rd_a_idx) == SP_IDX) |-> (rd_a_data == msp_q));

    // R4
    thread_proc_chk: assert property (@(posedge clk) disable iff (rst)
        (!handler_mode && thread_psp_sel && int'(rd_b_idx) == SP_IDX) |-> (rd_b_data == psp_q));

    // R9
    pc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_a_idx) == PC_IDX) |-> (rd_a_data == pc_in));

    // R6
    reset_load_chk: assert property (@(posedge clk)
        $fell(rst) |-> (psp_q == '0));

    // R2
    wide_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_a_narrow && !rd_b_narrow && !wr_narrow) |-> !narrow_bad);

endmodule

// File: tb/test_arch_regfile.sv
module test_arch_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] sp_reset_val = 32'h2000_1237;
    logic [DW-1:0] pc_in = '0;
    logic          handler_mode = 1'b0, thread_psp_sel = 1'b0;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic          rd_a_narrow = 1'b0, rd_b_narrow = 1'b0, wr_narrow = 1'b0;
    logic          wr_en = 1'b0, sp_acc_sel = 1'b0, sp_acc_we = 1'b0;
    logic [DW-1:0] wr_data = '0, sp_acc_wdata = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, sp_acc_rdata;
    logic          narrow_bad;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [DW-1:0] m_gpr [16];
    bit            m_val [16];
    logic [DW-1:0] m_msp, m_psp;

    arch_regfile #(.DATA_W(DW), .ALIGN_BITS(2)) i_arch_regfile (
        .clk(clk), .rst(rst), .sp_reset_val(sp_reset_val), .pc_in(pc_in),
        .handler_mode(handler_mode), .thread_psp_sel(thread_psp_sel),
        .rd_a_idx(rd_a_idx), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_narrow(wr_narrow), .wr_data(wr_data),
        .sp_acc_sel(sp_acc_sel), .sp_acc_we(sp_acc_we),
        .sp_acc_wdata(sp_acc_wdata), .sp_acc_rdata(sp_acc_rdata),
        .narrow_bad(narrow_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] algn(input logic [DW-1:0] x);
        return x & ~32'h3;
    endfunction

    function automatic bit use_proc();
        return !handler_mode && thread_psp_sel;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_read(input logic [3:0] idx, input logic [DW-1:0] act);
        if (idx == 4'd15) begin
            chk("R9", act, pc_in);
        end else if (idx == 4'd13) begin
            if (handler_mode) chk("R3", act, m_msp);
            else chk("R4", act, use_proc() ? m_psp : m_msp);
        end else if (m_val[idx]) begin
            chk("R1", act, m_gpr[idx]);
        end
    endtask

    task automatic compare_all();
        bit flag;
        check_read(rd_a_idx, rd_a_data);
        check_read(rd_b_idx, rd_b_data);
        chk("R5", sp_acc_rdata, sp_acc_sel ? m_psp : m_msp);
        flag = (rd_a_narrow && rd_a_idx > 4'd7) || (rd_b_narrow && rd_b_idx > 4'd7)
               || (wr_en && wr_narrow && wr_idx > 4'd7);
        chk("R2", {31'b0, narrow_bad}, {31'b0, flag});
    endtask

    task automatic model_update();
        bit tgt_proc;
        tgt_proc = use_proc();
        if (wr_en) begin
            if (wr_idx == 4'd13) begin
                if (!(sp_acc_we && sp_acc_sel == tgt_proc)) begin
                    if (tgt_proc) m_psp = algn(wr_data);
                    else m_msp = algn(wr_data);
                end
            end else if (wr_idx != 4'd15) begin
                m_gpr[wr_idx] = wr_data;
                m_val[wr_idx] = 1'b1;
            end
        end
        if (sp_acc_we) begin
            if (sp_acc_sel) m_psp = algn(sp_acc_wdata);
            else m_msp = algn(sp_acc_wdata);
        end
    endtask

    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; sp_acc_we = 0; wr_narrow = 0; rd_a_narrow = 0; rd_b_narrow = 0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [DW-1:0] d);
        idle(); wr_en = 1; wr_idx = idx; wr_data = d;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_val[i] = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_msp = 32'h2000_1234;
        m_psp = '0;
        #1;
        sp_acc_sel = 0; #1 chk("R6", sp_acc_rdata, 32'h2000_1234);
        sp_acc_sel = 1; #1 chk("R6", sp_acc_rdata, 32'h0000_0000);
        sp_acc_sel = 0;
        @(negedge clk);

        for (int i = 0; i < 16; i++) wr(4'(i), 32'hA5A5_0000 + 32'(i) * 32'h111);
        for (int i = 0; i < 16; i++) begin
            idle(); rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); step();
        end

        // R10
        wr(4'd3, 32'h1111_1111);
        idle(); wr_en = 1; wr_idx = 3; wr_data = 32'h2222_2222; rd_a_idx = 3;
        #1 chk("R10", rd_a_data, 32'h1111_1111);
        step();
        idle(); #1 chk("R10", rd_a_data, 32'h2222_2222);
        step();

        // R3
        handler_mode = 1; thread_psp_sel = 1;
        wr(4'd13, 32'hABCD_0003);
        idle(); rd_a_idx = 13; sp_acc_sel = 0;
        #1 chk("R3", rd_a_data, 32'hABCD_0000);
        chk("R7", sp_acc_rdata, 32'hABCD_0000);
        step();

        // R4
        handler_mode = 0;
        wr(4'd13, 32'h0000_4447);
        idle(); rd_b_idx = 13; sp_acc_sel = 1;
        #1 chk("R4", rd_b_data, 32'h0000_4444);
        sp_acc_sel = 0; #1 chk("R5", sp_acc_rdata, 32'hABCD_0000);
        step();

        // R8
        idle(); wr_en = 1; wr_idx = 13; wr_data = 32'h1111_1110;
        sp_acc_we = 1; sp_acc_sel = 1; sp_acc_wdata = 32'h2222_2221;
        step();
        idle(); sp_acc_sel = 1; #1 chk("R8", sp_acc_rdata, 32'h2222_2220);
        step();

        // R5
        handler_mode = 1;
        idle(); sp_acc_we = 1; sp_acc_sel = 1; sp_acc_wdata = 32'h3333_3333;
        step();
        idle(); sp_acc_sel = 1; #1 chk("R5", sp_acc_rdata, 32'h3333_3330);
        step();

        // R9
        pc_in = 32'hCAFE_F00C;
        wr(4'd15, 32'hDEAD_BEEF);
        idle(); rd_a_idx = 15; #1 chk("R9", rd_a_data, 32'hCAFE_F00C);
        step();

        // R2
        idle(); rd_a_narrow = 1; rd_a_idx = 8; #1 chk("R2", {31'b0, narrow_bad}, 32'h1);
        rd_a_idx = 7; #1 chk("R2", {31'b0, narrow_bad}, 32'h0);
        rd_a_narrow = 0; rd_a_idx = 12; #1 chk("R2", {31'b0, narrow_bad}, 32'h0);
        wr_en = 1; wr_narrow = 1; wr_idx = 9; wr_data = 32'h5; #1 chk("R2", {31'b0, narrow_bad}, 32'h1);
        step();

        for (int n = 0; n < 4000; n++) begin
            handler_mode   = ($urandom % 4) == 0;
            thread_psp_sel = $urandom % 2;
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
            rd_a_narrow = $urandom % 2; rd_b_narrow = $urandom % 2;
            wr_en = $urandom % 2; wr_idx = ($urandom % 3 == 0) ? 4'd13 : 4'($urandom);
            wr_narrow = $urandom % 2; wr_data = $urandom;
            sp_acc_we = ($urandom % 4) == 0; sp_acc_sel = $urandom % 2;
            sp_acc_wdata = $urandom; pc_in = $urandom;
            step();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule